// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

The block moves transmit frames out of system memory under control of a ring of buffer descriptors kept in a small internal descriptor store. Each descriptor takes two adjacent 32-bit words. Word 0 holds the flags and the frame length. Word 1 holds the buffer start address. Software fills the descriptor words and the control registers through a simple register port. When it sets the ready flag of a descriptor, the engine claims that descriptor. It reads the buffer one word at a time through a request/acknowledge memory master and hands the bytes, most significant first, to a byte sink over a valid/ready stream.

When the frame is finished, the engine writes the updated flag word back into the descriptor store and sets an interrupt-source bit. It may raise the interrupt line. It then moves on to the next descriptor pair. With each frame it also presents the length limits and the checksum-append decision to the downstream framer. The byte sink can end a frame early with an abort input, and the engine then reports the frame as failed.

Top module: `txring_dma`

## Requirements
- R1: The engine claims the descriptor at its current index only when mode bit 0 (transmit enable) is set and bit 15 (ready) of word 0 is set. Until then it keeps polling that same index and issues no memory request and no byte.
- R2: A frame of length L (word 0 bits 31:16) is read from the address in word 1, stepping by 4. Each word is emitted as four bytes, bits 31:24 first. Exactly L bytes are sent, and tx_last marks the final one. mem_req and mem_addr hold until mem_ack.
- R3: While tx_valid is high and tx_ready and tx_abort are low, tx_data stays unchanged into the next cycle.
- R4: On claim, the status flags are cleared: bit 0 defer, bit 1 collision, bit 2 retransmit, bit 3 underrun, bit 8 no-carrier, and the retry count in bits 7:4 is set to zero. The written-back word 0 also has ready cleared. All other flags and the length are kept.
- R5: A frame whose last byte is accepted sets interrupt-source bit 0 (register 0x01). A zero-length frame is completed without any memory read.
- R6: If tx_abort is high while a byte is offered, the frame ends at once and no further bytes are sent. Ready and collision are cleared in the written-back word, and interrupt-source bit 1 is set.
- R7: At completion, irq rises only if the interrupt mask (register 0x02, bits 1:0) is nonzero, word 0 bit 14 (IRQ) is set, and irq is currently low.
- R8: Writing the interrupt-source register clears each bit written as one. Writing zero has no effect. irq falls only when such a write leaves no source bit set.
- R9: After a descriptor, the index returns to 0 if word 0 bit 13 (wrap) is set or the index equals WORDS-2. Otherwise it advances by 2.
- R10: tx_min_len is the programmed minimum (register 0x03 bits 31:16) when word 0 bit 12 (pad) or mode bit 1 is set, else L. tx_max_len is L when mode bit 3 (huge) is set, else the programmed maximum (register 0x03 bits 15:0).
- R11: tx_crc_add is high when mode bit 2 is set, or when word 0 has both bit 11 (checksum) and bit 10 (final fragment) set.
- R12: Writing register 0x04 keeps only bits 7:0 of the value. rx_desc_idx then equals that count shifted left by one.
- R13: After reset, all registers and descriptor words (0x80 + word number) read zero, and irq, tx_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address; 0x80 and above selects descriptor words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte offered |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Offered byte is the final one of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_abort | input | 1 | Sink abandons the current frame |
| tx_crc_add | output | 1 | Checksum append decision for the frame |
| tx_min_len | output | 16 | Effective minimum frame length |
| tx_max_len | output | 16 | Effective maximum frame length |
| irq | output | 1 | Interrupt line |
| rx_desc_idx | output | 9 | Receive descriptor start index |

## Verification
Frames of several lengths are sent from different buffers. Lengths that end mid-word and on a word boundary separate the byte-lane order from the address stepping. One frame runs under alternating backpressure and one is aborted after two bytes, which tells a clean stop from a leak of further bytes. The flag combinations are varied across descriptors: per-descriptor pad versus global pad, huge mode, global versus per-descriptor checksum, IRQ flag with and without a mask. Each combination shows in the per-byte side outputs or in the interrupt line. Descriptors placed at the ring limit, with the wrap flag, and a ready descriptor that must be skipped separate the two ways the index returns to zero.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int WORD_W = 32;

    // register word addresses (low seven bits, bit 7 clear)
    localparam logic [6:0] RA_MODE  = 7'h00;
    localparam logic [6:0] RA_ISRC  = 7'h01;
    localparam logic [6:0] RA_IMASK = 7'h02;
    localparam logic [6:0] RA_FLEN  = 7'h03;
    localparam logic [6:0] RA_DCNT  = 7'h04;

    typedef struct packed {
        logic [15:0] len;
        logic        ready;
        logic        irq;
        logic        wrap;
        logic        pad;
        logic        crc;
        logic        fin;
        logic        spare;
        logic        no_carrier;
        logic [3:0]  retry;
        logic        underrun;
        logic        retransmit;
        logic        collision;
        logic        defer;
    } desc_w0_t;

    typedef struct packed {
        logic huge;
        logic crc_en;
        logic pad;
        logic tx_en;
    } mode_t;

    typedef struct packed {
        logic        crc_add;
        logic [15:0] min_len;
        logic [15:0] max_len;
    } frame_info_t;

    typedef enum logic [1:0] {
        ST_POLL,
        ST_FETCH,
        ST_STREAM,
        ST_WB
    } eng_state_t;

    function automatic desc_w0_t claim_clear(input desc_w0_t w);
        desc_w0_t r;
        r            = w;
        r.defer      = 1'b0;
        r.collision  = 1'b0;
        r.retransmit = 1'b0;
        r.underrun   = 1'b0;
        r.no_carrier = 1'b0;
        r.retry      = 4'd0;
        return r;
    endfunction

    function automatic frame_info_t frame_limits(input desc_w0_t w, input mode_t m,
                                                 input logic [15:0] min_reg,
                                                 input logic [15:0] max_reg);
        frame_info_t f;
        f.min_len = (w.pad || m.pad) ? min_reg : w.len;
        f.max_len = m.huge ? w.len : max_reg;
        f.crc_add = m.crc_en || (w.crc && w.fin);
        return f;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] word, input logic [1:0] sel);
        logic [7:0] b;
        case (sel)
            2'd0:    b = word[31:24];
            2'd1:    b = word[23:16];
            2'd2:    b = word[15:8];
            default: b = word[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/txring_desc_ram.sv
module txring_desc_ram
    import txring_pkg::*;
#(
    parameter  int WORDS = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [WORD_W-1:0] eng_wdata,
    output logic [WORD_W-1:0] pair_w0,
    output logic [WORD_W-1:0] pair_w1
);

    logic [WORDS*WORD_W-1:0] flat;
    logic [IDX_W-1:0]        odd_idx;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (eng_we && eng_idx == IDX_W'(g)) begin
                q <= eng_wdata;      // engine write-back wins a same-word clash
            end else if (sw_we && sw_idx == IDX_W'(g)) begin
                q <= sw_wdata;
            end
        end
        assign flat[g*WORD_W +: WORD_W] = q;
    end

    assign odd_idx  = {eng_idx[IDX_W-1:1], 1'b1};
    assign sw_rdata = flat[{sw_idx, 5'b0} +: WORD_W];
    assign pair_w0  = flat[{eng_idx, 5'b0} +: WORD_W];
    assign pair_w1  = flat[{odd_idx, 5'b0} +: WORD_W];

endmodule

// File: rtl/txring_regs.sv
module txring_regs
    import txring_pkg::*;
#(
    parameter  int WORDS = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_idx,
    input  logic [WORD_W-1:0] ram_rdata,
    output mode_t             mode,
    output logic [15:0]       min_reg,
    output logic [15:0]       max_reg,
    input  logic              wb_en,
    input  logic              wb_ok,
    input  logic              wb_irq_flag,
    output logic              irq,
    output logic [8:0]        rx_desc_idx
);

    logic [1:0]        isrc_q, imask_q, isrc_clr, isrc_set, isrc_next;
    logic [WORD_W-1:0] flen_q;
    logic [7:0]        dcnt_q;
    logic              ram_hit, ctl_we, isrc_wr, raise;

    assign ram_hit = reg_addr[6:0] < 7'(WORDS);
    assign ram_idx = reg_addr[IDX_W-1:0];
    assign ram_we  = reg_we && reg_addr[7] && ram_hit;
    assign ctl_we  = reg_we && !reg_addr[7];
    assign isrc_wr = ctl_we && reg_addr[6:0] == RA_ISRC;

    assign isrc_clr  = isrc_wr ? reg_wdata[1:0] : 2'b00;
    assign isrc_set  = {wb_en && !wb_ok, wb_en && wb_ok};
    assign isrc_next = (isrc_q & ~isrc_clr) | isrc_set;
    assign raise     = wb_en && wb_irq_flag && (|imask_q) && !irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            isrc_q  <= '0;
            imask_q <= '0;
            flen_q  <= '0;
            dcnt_q  <= '0;
            irq     <= 1'b0;
        end else begin
            isrc_q <= isrc_next;
            if (raise) begin
                irq <= 1'b1;
            end else if (isrc_wr && isrc_next == 2'b00) begin
                irq <= 1'b0;
            end
            if (ctl_we) begin
                case (reg_addr[6:0])
                    RA_MODE:  mode    <= mode_t'(reg_wdata[3:0]);
                    RA_IMASK: imask_q <= reg_wdata[1:0];
                    RA_FLEN:  flen_q  <= reg_wdata;
                    RA_DCNT:  dcnt_q  <= reg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    assign min_reg     = flen_q[31:16];
    assign max_reg     = flen_q[15:0];
    assign rx_desc_idx = {dcnt_q, 1'b0};

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[7]) begin
            if (ram_hit) reg_rdata = ram_rdata;
        end else begin
            case (reg_addr[6:0])
                RA_MODE:  reg_rdata = {28'd0, mode};
                RA_ISRC:  reg_rdata = {30'd0, isrc_q};
                RA_IMASK: reg_rdata = {30'd0, imask_q};
                RA_FLEN:  reg_rdata = flen_q;
                RA_DCNT:  reg_rdata = {24'd0, dcnt_q};
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
#(
    parameter  int WORDS = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic [15:0]       min_reg,
    input  logic [15:0]       max_reg,
    output logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] pair_w0,
    input  logic [WORD_W-1:0] pair_w1,
    output logic              wb_en,
    output logic              wb_ok,
    output logic              wb_irq_flag,
    output logic [WORD_W-1:0] wb_data,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              tx_abort,
    output frame_info_t       info
);

    localparam logic [IDX_W-1:0] RING_LIMIT = IDX_W'(WORDS - 2);

    eng_state_t        state;
    desc_w0_t          w0_in, flags, wb_word;
    logic [WORD_W-1:0] addr, word;
    logic [15:0]       sent;
    logic [1:0]        sel;
    logic              ok, is_last;

    assign w0_in   = desc_w0_t'(pair_w0);
    assign is_last = sent == flags.len - 16'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_POLL;
            idx   <= '0;
            flags <= '0;
            addr  <= '0;
            word  <= '0;
            sent  <= '0;
            sel   <= '0;
            ok    <= 1'b1;
            info  <= '0;
        end else begin
            case (state)
                ST_POLL: begin
                    if (mode.tx_en && w0_in.ready) begin
                        flags <= claim_clear(w0_in);
                        info  <= frame_limits(w0_in, mode, min_reg, max_reg);
                        addr  <= pair_w1;
                        sent  <= '0;
                        sel   <= '0;
                        ok    <= 1'b1;
                        state <= (w0_in.len == 16'd0) ? ST_WB : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        word  <= mem_rdata;
                        sel   <= '0;
                        state <= ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (tx_abort) begin
                        ok    <= 1'b0;
                        state <= ST_WB;
                    end else if (tx_ready) begin
                        sent <= sent + 16'd1;
                        if (is_last) begin
                            state <= ST_WB;
                        end else if (sel == 2'd3) begin
                            addr  <= addr + WORD_W'(4);
                            state <= ST_FETCH;
                        end else begin
                            sel <= sel + 2'd1;
                        end
                    end
                end
                default: begin
                    idx   <= (flags.wrap || idx >= RING_LIMIT) ? '0 : idx + IDX_W'(2);
                    state <= ST_POLL;
                end
            endcase
        end
    end

    always_comb begin
        wb_word       = flags;
        wb_word.ready = 1'b0;
        if (!ok) wb_word.collision = 1'b0;
    end

    assign wb_en       = state == ST_WB;
    assign wb_ok       = ok;
    assign wb_irq_flag = flags.irq;
    assign wb_data     = wb_word;
    assign mem_req     = state == ST_FETCH;
    assign mem_addr    = addr;
    assign tx_valid    = state == ST_STREAM;
    assign tx_data     = pick_byte(word, sel);
    assign tx_last     = tx_valid && is_last;

endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter  int WORDS = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        tx_abort,
    output logic        tx_crc_add,
    output logic [15:0] tx_min_len,
    output logic [15:0] tx_max_len,
    output logic        irq,
    output logic [8:0]  rx_desc_idx
);

    logic              ram_we, wb_en, wb_ok, wb_irq_flag;
    logic [IDX_W-1:0]  ram_idx, eng_idx;
    logic [WORD_W-1:0] ram_rdata, pair_w0, pair_w1, wb_data;
    logic [15:0]       min_reg, max_reg;
    logic [7:0]        chk_idx;
    mode_t             mode;
    frame_info_t       info;

    txring_regs #(.WORDS(WORDS)) regs_i (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_we(ram_we), .ram_idx(ram_idx), .ram_rdata(ram_rdata),
        .mode(mode), .min_reg(min_reg), .max_reg(max_reg),
        .wb_en(wb_en), .wb_ok(wb_ok), .wb_irq_flag(wb_irq_flag),
        .irq(irq), .rx_desc_idx(rx_desc_idx)
    );

    txring_desc_ram #(.WORDS(WORDS)) ram_i (
        .clk(clk), .rst(rst),
        .sw_we(ram_we), .sw_idx(ram_idx), .sw_wdata(reg_wdata), .sw_rdata(ram_rdata),
        .eng_we(wb_en), .eng_idx(eng_idx), .eng_wdata(wb_data),
        .pair_w0(pair_w0), .pair_w1(pair_w1)
    );

    txring_engine #(.WORDS(WORDS)) eng_i (
        .clk(clk), .rst(rst),
        .mode(mode), .min_reg(min_reg), .max_reg(max_reg),
        .idx(eng_idx), .pair_w0(pair_w0), .pair_w1(pair_w1),
        .wb_en(wb_en), .wb_ok(wb_ok), .wb_irq_flag(wb_irq_flag), .wb_data(wb_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_abort(tx_abort), .info(info)
    );

    assign chk_idx    = 8'(eng_idx);
    assign tx_crc_add = info.crc_add;
    assign tx_min_len = info.min_len;
    assign tx_max_len = info.max_len;

endmodule

// File: rtl/txring_checker.sv
module txring_checker (
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_abort,
    input logic [7:0]  tx_data,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        irq,
    input logic        wb_en,
    input logic [7:0]  chk_idx
);

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !tx_abort) |=> (tx_valid && $stable(tx_data))); // R3

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && mem_req)); // R2

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(wb_en)); // R7

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> (chk_idx == 8'd0 || chk_idx == $past(chk_idx) + 8'd2)); // R9

endmodule

bind txring_dma txring_checker chk_i (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_abort(tx_abort), .tx_data(tx_data),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .irq(irq), .wb_en(wb_en), .chk_idx(chk_idx)
);

// File: tb/txring_dma_tb_top.sv
`timescale 1ns/1ps
module txring_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        tx_valid, tx_last, tx_crc_add, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1, tx_abort = 1'b0;
    logic [15:0] tx_min_len, tx_max_len;
    logic [8:0]  rx_desc_idx;

    int n_chk = 0, n_fail = 0;
    int memreq_cnt = 0, valid_cnt = 0;
    int abort_after = 0, acc_cnt = 0;
    bit abort_now = 0, bp_mode = 0, done = 0;

    typedef struct {
        logic [7:0]  d;
        logic        last;
        logic        crc;
        logic [15:0] mn;
        logic [15:0] mx;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    txring_dma #(.WORDS(8)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_abort(tx_abort), .tx_crc_add(tx_crc_add),
        .tx_min_len(tx_min_len), .tx_max_len(tx_max_len), .irq(irq), .rx_desc_idx(rx_desc_idx)
    );

    function automatic logic [31:0] memword(input logic [31:0] a);
        logic [7:0] k;
        k = a[9:2];
        return {k ^ 8'h5A, k + 8'h11, ~k, k + 8'h80};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [31:0] base, input int k);
        logic [31:0] w;
        w = memword(base + 32'(4 * (k / 4)));
        return w[31 - 8 * (k % 4) -: 8];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // memory responder: acknowledges one cycle after a request appears
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= memword(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
        if (mem_req) memreq_cnt++;
        if (tx_valid) valid_cnt++;
    end

    // sink driver and scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            tx_ready = 1'b1;
            tx_abort = 1'b0;
        end else begin
            if (abort_now) begin
                tx_ready  = 1'b0;
                tx_abort  = 1'b1;
                abort_now = 0;
            end else begin
                tx_abort = 1'b0;
                tx_ready = bp_mode ? ~tx_ready : 1'b1;
            end
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected byte after frame end", {24'd0, tx_data}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(tx_data == e.d, "R2 byte value", {24'd0, tx_data}, {24'd0, e.d});
                    chk(tx_last == e.last, "R2 last marker", {31'd0, tx_last}, {31'd0, e.last});
                    chk(tx_crc_add == e.crc, "R11 crc append", {31'd0, tx_crc_add}, {31'd0, e.crc});
                    chk(tx_min_len == e.mn, "R10 min length", {16'd0, tx_min_len}, {16'd0, e.mn});
                    chk(tx_max_len == e.mx, "R10 max length", {16'd0, tx_max_len}, {16'd0, e.mx});
                end
                acc_cnt++;
                if (abort_after != 0 && acc_cnt == abort_after) begin
                    abort_now   = 1;
                    abort_after = 0;
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push_frame(input logic [31:0] base, input int len, input int n_acc,
                              input logic crc, input logic [15:0] mn, input logic [15:0] mx);
        for (int k = 0; k < n_acc; k++) begin
            exp_t e;
            e.d = exp_byte(base, k); e.last = (k == len - 1);
            e.crc = crc; e.mn = mn; e.mx = mx;
            exp_q.push_back(e);
        end
    endtask

    task automatic wait_desc_done(input int w, input string tag);
        logic [31:0] d;
        int n;
        n = 0;
        rd(8'h80 + 8'(w), d);
        while (d[15] && n < 400) begin
            rd(8'h80 + 8'(w), d);
            n++;
        end
        chk(!d[15], tag, d, {d[31:16], 1'b0, d[14:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        chk(irq == 1'b0, "R13 irq after reset", {31'd0, irq}, 32'd0);
        chk(tx_valid == 1'b0 && mem_req == 1'b0, "R13 idle outputs", {30'd0, tx_valid, mem_req}, 32'd0);
        rd(8'h00, d); chk(d == 32'd0, "R13 mode reads zero", d, 32'd0);
        rd(8'h03, d); chk(d == 32'd0, "R13 length limits read zero", d, 32'd0);
        rd(8'h80, d); chk(d == 32'd0, "R13 descriptor word reads zero", d, 32'd0);

        // R12 descriptor count register
        wr(8'h04, 32'h0000_1A5C);
        rd(8'h04, d); chk(d == 32'h5C, "R12 count keeps low byte", d, 32'h5C);
        chk(rx_desc_idx == 9'h0B8, "R12 rx index is count times two", {23'd0, rx_desc_idx}, 32'h0B8);

        // R1: ready descriptor with transmit disabled is left alone
        wr(8'h02, 32'h1);
        wr(8'h03, 32'h003C_05DC);
        wr(8'h81, 32'h0000_0100);
        wr(8'h80, 32'h0006_CD5A);   // ready irq crc fin, stale status bits
        memreq_cnt = 0; valid_cnt = 0;
        repeat (20) @(negedge clk);
        chk(memreq_cnt == 0 && valid_cnt == 0, "R1 no activity while disabled", 32'(memreq_cnt + valid_cnt), 32'd0);

        // R2 R4 R5 R7 R11: six-byte frame, checksum from descriptor flags
        push_frame(32'h100, 6, 6, 1'b1, 16'd6, 16'd1500);
        wr(8'h00, 32'h1);
        wait_desc_done(0, "R1 descriptor 0 completes");
        chk(exp_q.size() == 0, "R2 all bytes of frame 0 sent", 32'(exp_q.size()), 32'd0);
        rd(8'h80, d); chk(d == 32'h0006_4C00, "R4 status cleared in write-back", d, 32'h0006_4C00);
        rd(8'h01, d); chk(d == 32'h1, "R5 done source bit", d, 32'h1);
        chk(irq == 1'b1, "R7 irq raised", {31'd0, irq}, 32'd1);

        // R8 write-one-to-clear
        wr(8'h01, 32'h0);
        chk(irq == 1'b1, "R8 zero write has no effect", {31'd0, irq}, 32'd1);
        wr(8'h01, 32'h2);
        rd(8'h01, d); chk(d == 32'h1 && irq, "R8 clearing unset bit keeps line", {d[30:0], irq}, 32'h3);
        wr(8'h01, 32'h1);
        rd(8'h01, d); chk(d == 32'h0, "R8 source cleared", d, 32'h0);
        chk(irq == 1'b0, "R8 line drops", {31'd0, irq}, 32'd0);

        // R3 R7 R10: nine bytes under backpressure, descriptor pad, huge mode, mask zero
        wr(8'h02, 32'h0);
        wr(8'h00, 32'h9);
        push_frame(32'h200, 9, 9, 1'b0, 16'd60, 16'd9);
        bp_mode = 1;
        wr(8'h83, 32'h0000_0200);
        wr(8'h82, 32'h0009_D000);   // ready irq pad
        wait_desc_done(2, "R9 descriptor 2 completes");
        bp_mode = 0;
        chk(exp_q.size() == 0, "R3 all bytes under backpressure", 32'(exp_q.size()), 32'd0);
        chk(irq == 1'b0, "R7 no irq with mask zero", {31'd0, irq}, 32'd0);
        rd(8'h01, d); chk(d == 32'h1, "R5 source set despite mask", d, 32'h1);
        wr(8'h01, 32'h3);

        // R7 R10 R11: global pad and checksum, no IRQ flag
        wr(8'h02, 32'h3);
        wr(8'h00, 32'h7);
        push_frame(32'h300, 4, 4, 1'b1, 16'd60, 16'd1500);
        wr(8'h85, 32'h0000_0300);
        wr(8'h84, 32'h0004_8000);
        wait_desc_done(4, "R9 descriptor 4 completes");
        chk(exp_q.size() == 0, "R2 word-sized frame", 32'(exp_q.size()), 32'd0);
        chk(irq == 1'b0, "R7 no irq without descriptor flag", {31'd0, irq}, 32'd0);
        wr(8'h01, 32'h3);

        // R6: abort after two bytes at the ring-limit descriptor
        wr(8'h02, 32'h2);
        wr(8'h00, 32'h1);
        push_frame(32'h400, 8, 2, 1'b0, 16'd8, 16'd1500);
        acc_cnt = 0; abort_after = 2;
        wr(8'h87, 32'h0000_0400);
        wr(8'h86, 32'h0008_C002);   // ready irq collision
        wait_desc_done(6, "R6 aborted descriptor released");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 bytes before abort", 32'(exp_q.size()), 32'd0);
        rd(8'h86, d); chk(d == 32'h0008_4000, "R6 ready and collision cleared", d, 32'h0008_4000);
        rd(8'h01, d); chk(d == 32'h2, "R6 error source bit", d, 32'h2);
        chk(irq == 1'b1, "R7 irq on error mask", {31'd0, irq}, 32'd1);
        wr(8'h01, 32'h2);
        chk(irq == 1'b0, "R8 line drops after error clear", {31'd0, irq}, 32'd0);

        // R9 ring limit returns to index 0; R5 zero-length descriptor
        push_frame(32'h500, 3, 3, 1'b0, 16'd3, 16'd1500);
        wr(8'h81, 32'h0000_0500);
        wr(8'h80, 32'h0003_8000);
        wait_desc_done(0, "R9 index 0 after ring limit");
        chk(exp_q.size() == 0, "R9 frame from index 0", 32'(exp_q.size()), 32'd0);

        // R9 wrap flag: index 2 wraps, ready descriptor at index 4 is skipped
        memreq_cnt = 0;
        wr(8'h85, 32'h0000_0800);
        wr(8'h84, 32'h0002_8000);
        wr(8'h81, 32'h0000_0700);
        wr(8'h80, 32'h0000_8000);   // zero length at index 0
        push_frame(32'h600, 5, 5, 1'b0, 16'd5, 16'd1500);
        wr(8'h83, 32'h0000_0600);
        wr(8'h82, 32'h0005_A000);   // ready wrap
        wait_desc_done(2, "R9 wrap descriptor completes");
        wait_desc_done(0, "R5 zero-length descriptor completes");
        chk(exp_q.size() == 0, "R9 wrap frame bytes", 32'(exp_q.size()), 32'd0);
        chk(memreq_cnt == 2, "R5 zero length reads no memory", 32'(memreq_cnt), 32'd2);
        repeat (20) @(negedge clk);
        rd(8'h84, d); chk(d[15] == 1'b1, "R9 index 4 skipped after wrap", d, 32'h0002_8000);
        memreq_cnt = 0;
        repeat (10) @(negedge clk);
        chk(memreq_cnt == 0, "R1 polling idle descriptor makes no requests", 32'(memreq_cnt), 32'd0);

        done = 1;
        finish_run();
    end

endmodule